// File: doc/BRIEF.md
# Gain-Aware ADC Acquisition Sequencer

This block is the control core of a four-channel differential analog input module that sits on a byte-wide register bus. Software programs a channel-list entry, a settling count and a timebase code. It then starts a conversion by reading a dedicated strobe offset. The read itself has the side effect of launching the sequence. The block drives the channel, gain and multiplexer selects to the analog front end, and it waits out the settling interval. It then issues a one-cycle start to an external converter and waits for that converter's done strobe. Finally it latches the 16-bit two's complement sample into two readable bytes.

Status reporting has two parts. A pending flag reads 1 from the strobe until the sample is latched. Sticky error flags record a start that arrives while a conversion is already in progress, and a start issued with a zero settling count. Software clears the error flags by writing ones to them. The settling count can be restarted in mid-flight. Clearing the module enable abandons any conversion in progress.

Top module: `adc_acq_seq`

## Requirements
- R1: After reset, offset 0x00 reads the identification value 0x77, and offsets 0x01, 0x02, 0x03 and 0x12 read 0x00.
- R2: A bus read of offset 0x04 while the enable (bit 2 of offset 0x10) is set and no conversion is running starts a conversion. From the next cycle until the sample is latched, bit 7 of offset 0x01 (busy) and bit 7 of offset 0x12 (pending) read 1.
- R3: `cnv_start` is high for exactly one cycle. Its rising edge follows the edge that sampled the start read by N*D+1 cycles. N is the settling count at offset 0x15 and D = 2^(code*TB_STEP_LOG2), with code taken from bits [2:1] of offset 0x11.
- R4: `cnv_done`, sampled high in the cycle after the start pulse or later, latches `cnv_data`. Bits [7:0] of the sample read at offset 0x02 and bits [15:8] at offset 0x03. Busy and pending read 0 from the next cycle.
- R5: `cnv_done` while no conversion is waiting leaves offsets 0x02 and 0x03 unchanged.
- R6: A start read while a conversion runs sets the data error flag (bit 1 of offset 0x12) and does not alter the timing of the running conversion.
- R7: A start read with a settling count of 0 sets the settling error flag (bit 0 of offset 0x12), and the converter start still follows after one cycle.
- R8: A write to offset 0x12 clears each error flag whose bit in the written byte is 1 and leaves the others. Bit 2 of offset 0x12 always reads 0.
- R9: A write to offset 0x1B during settling reloads the settling count and timebase phase. The start pulse then follows that write's edge by N*D+1 cycles.
- R10: A start read while the enable is clear has no effect. Clearing the enable during a conversion returns the block to idle with busy at 0, and no start pulse follows.
- R11: Offset 0x80 holds the channel-list entry: bits [1:0] channel to `fe_chan`, bit 2 to `fe_mux_en`, bits [4:3] gain code to `fe_gain`, bit 5 to `fe_board_only`. It reads back bits [5:0]. Offset 0x11 reads back bits [5:0] of its last write, and `fe_enable` follows bit 2 of offset 0x10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 8 | Register offset |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access (side effect at 0x04) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| cnv_start | output | 1 | One-cycle converter start |
| cnv_done | input | 1 | Converter result valid |
| cnv_data | input | 16 | Converter result, two's complement |
| fe_enable | output | 1 | Module enable to the front end |
| fe_chan | output | 2 | Selected input channel |
| fe_gain | output | 2 | Selected gain code |
| fe_mux_en | output | 1 | Input multiplexer enable |
| fe_board_only | output | 1 | On-board-only selection from the channel list |

## Verification
The bench builds the block with TB_STEP_LOG2 = 1, so the four timebase codes divide by 1, 2, 4 and 8. This keeps the longest settling window under a hundred cycles. The bench can therefore sweep every timebase code against every settling count from 0 to 9 and compare each start-pulse delay with N*D+1. That short window also makes it cheap to place a second start, a counter restart and a disable at known cycles inside settling. The channel-list entry is swept over all 64 values of its six bits.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    localparam int BYTE_W = 8;
    localparam int ADDR_W = 8;
    localparam int RES_W  = 2 * BYTE_W;
    localparam int OPT_W  = 6;
    localparam int CL_W   = 6;

    // register offsets (software decodes these)
    localparam logic [ADDR_W-1:0] OFS_IDENT   = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_CMDSTAT = 8'h01;
    localparam logic [ADDR_W-1:0] OFS_RES_LO  = 8'h02;
    localparam logic [ADDR_W-1:0] OFS_RES_HI  = 8'h03;
    localparam logic [ADDR_W-1:0] OFS_SWSTART = 8'h04;
    localparam logic [ADDR_W-1:0] OFS_CONFIG  = 8'h10;
    localparam logic [ADDR_W-1:0] OFS_OPTION  = 8'h11;
    localparam logic [ADDR_W-1:0] OFS_STATUS  = 8'h12;
    localparam logic [ADDR_W-1:0] OFS_SETTLE  = 8'h15;
    localparam logic [ADDR_W-1:0] OFS_CNTRST  = 8'h1B;
    localparam logic [ADDR_W-1:0] OFS_CHLIST  = 8'h80;

    localparam int CFG_EN_BIT = 2;

    typedef enum logic [1:0] {
        SEQ_IDLE,
        SEQ_SETTLE,
        SEQ_FIRE,
        SEQ_WAIT
    } seq_state_e;

    // channel-list entry, MSB first: bit5 .. bit0
    typedef struct packed {
        logic       board_only;
        logic [1:0] gain;
        logic       mux_en;
        logic [1:0] chan;
    } chlist_t;

endpackage

// File: rtl/adc_seq_timebase.sv
module adc_seq_timebase
    import adc_seq_pkg::*;
#(
    parameter int STEP_LOG2 = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic       restart,
    input  logic [1:0] code,
    output logic       tick
);
    localparam int PRE_W = 3 * STEP_LOG2;

    logic [PRE_W-1:0] pre_d, pre_q;
    logic [PRE_W-1:0] limit;

    // limit = 2^(code*STEP_LOG2) - 1
    always_comb begin
        for (int i = 0; i < PRE_W; i++) begin
            limit[i] = (i < int'(code) * STEP_LOG2);
        end
    end

    always_comb begin
        tick  = run && !restart && (pre_q == limit);
        pre_d = pre_q + 1'b1;
        if (!run || restart || tick) begin
            pre_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q <= '0;
        end else begin
            pre_q <= pre_d;
        end
    end

endmodule

// File: rtl/adc_seq_regs.sv
module adc_seq_regs
    import adc_seq_pkg::*;
#(
    parameter logic [BYTE_W-1:0] ID_VALUE = 8'h77
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [BYTE_W-1:0] bus_wdata,
    output logic [BYTE_W-1:0] bus_rdata,
    input  logic              busy,
    input  logic [RES_W-1:0]  result,
    input  logic              data_err,
    input  logic              settle_err,
    output logic              enable,
    output logic [1:0]        tb_code,
    output logic [BYTE_W-1:0] settle_cnt,
    output chlist_t           chlist,
    output logic              start_req,
    output logic              cnt_rst,
    output logic [1:0]        err_clr
);
    typedef struct packed {
        logic              en;
        logic [OPT_W-1:0]  opt;
        logic [BYTE_W-1:0] cnt;
        chlist_t           cl;
    } regs_t;

    regs_t r_d, r_q;

    logic unused_wdata_hi;
    assign unused_wdata_hi = ^bus_wdata[BYTE_W-1:CL_W];

    always_comb begin
        r_d = r_q;
        if (bus_wr) begin
            unique case (bus_addr)
                OFS_CONFIG: r_d.en  = bus_wdata[CFG_EN_BIT];
                OFS_OPTION: r_d.opt = bus_wdata[OPT_W-1:0];
                OFS_SETTLE: r_d.cnt = bus_wdata;
                OFS_CHLIST: r_d.cl  = chlist_t'(bus_wdata[CL_W-1:0]);
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            OFS_IDENT:   bus_rdata = ID_VALUE;
            OFS_CMDSTAT: bus_rdata = {busy, 7'b0};
            OFS_RES_LO:  bus_rdata = result[BYTE_W-1:0];
            OFS_RES_HI:  bus_rdata = result[RES_W-1:BYTE_W];
            OFS_CONFIG:  bus_rdata = {5'b0, r_q.en, 2'b0};
            OFS_OPTION:  bus_rdata = {2'b0, r_q.opt};
            OFS_STATUS:  bus_rdata = {busy, 4'b0, 1'b0, data_err, settle_err};
            OFS_SETTLE:  bus_rdata = r_q.cnt;
            OFS_CHLIST:  bus_rdata = {2'b0, r_q.cl};
            default:     bus_rdata = '0;
        endcase
    end

    assign enable     = r_q.en;
    assign tb_code    = r_q.opt[2:1];
    assign settle_cnt = r_q.cnt;
    assign chlist     = r_q.cl;
    assign start_req  = bus_rd && (bus_addr == OFS_SWSTART);
    assign cnt_rst    = bus_wr && (bus_addr == OFS_CNTRST);
    assign err_clr    = (bus_wr && (bus_addr == OFS_STATUS)) ? bus_wdata[1:0] : 2'b00;

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
    import adc_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              start_req,
    input  logic              cnt_rst,
    input  logic [1:0]        err_clr,
    input  logic [BYTE_W-1:0] settle_cnt,
    input  logic              tick,
    input  logic              cnv_done,
    input  logic [RES_W-1:0]  cnv_data,
    output logic              busy,
    output logic              cnv_start,
    output logic              tb_run,
    output logic              tb_restart,
    output logic [RES_W-1:0]  result,
    output logic              data_err,
    output logic              settle_err
);
    typedef struct packed {
        seq_state_e        st;
        logic [BYTE_W-1:0] rem;
        logic [RES_W-1:0]  res;
        logic              derr;
        logic              serr;
    } ctrl_t;

    ctrl_t c_d, c_q;

    always_comb begin
        c_d = c_q;
        if (err_clr[1]) c_d.derr = 1'b0;
        if (err_clr[0]) c_d.serr = 1'b0;

        unique case (c_q.st)
            SEQ_IDLE: begin
                if (start_req && enable) begin
                    c_d.st  = SEQ_SETTLE;
                    c_d.rem = settle_cnt;
                    if (settle_cnt == '0) c_d.serr = 1'b1;
                end
            end
            SEQ_SETTLE: begin
                if (cnt_rst) begin
                    c_d.rem = settle_cnt;
                end else if (c_q.rem == '0) begin
                    c_d.st = SEQ_FIRE;
                end else if (tick) begin
                    c_d.rem = c_q.rem - 1'b1;
                end
            end
            SEQ_FIRE: c_d.st = SEQ_WAIT;
            SEQ_WAIT: begin
                if (cnv_done) begin
                    c_d.res = cnv_data;
                    c_d.st  = SEQ_IDLE;
                end
            end
            default: c_d.st = SEQ_IDLE;
        endcase

        if ((c_q.st != SEQ_IDLE) && start_req && enable) begin
            c_d.derr = 1'b1;
        end
        if (!enable) begin
            c_d.st = SEQ_IDLE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q <= '{st: SEQ_IDLE, rem: '0, res: '0, derr: 1'b0, serr: 1'b0};
        end else begin
            c_q <= c_d;
        end
    end

    assign busy       = (c_q.st != SEQ_IDLE);
    assign cnv_start  = (c_q.st == SEQ_FIRE);
    assign tb_run     = (c_q.st == SEQ_SETTLE);
    assign tb_restart = cnt_rst && (c_q.st == SEQ_SETTLE);
    assign result     = c_q.res;
    assign data_err   = c_q.derr;
    assign settle_err = c_q.serr;

endmodule

// File: rtl/adc_acq_seq.sv
module adc_acq_seq
    import adc_seq_pkg::*;
#(
    parameter int                TB_STEP_LOG2 = 2,
    parameter logic [BYTE_W-1:0] ID_VALUE     = 8'h77
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [BYTE_W-1:0] bus_wdata,
    output logic [BYTE_W-1:0] bus_rdata,
    output logic              cnv_start,
    input  logic              cnv_done,
    input  logic [RES_W-1:0]  cnv_data,
    output logic              fe_enable,
    output logic [1:0]        fe_chan,
    output logic [1:0]        fe_gain,
    output logic              fe_mux_en,
    output logic              fe_board_only
);
    logic              seq_busy;
    logic [RES_W-1:0]  seq_result;
    logic              derr, serr;
    logic [1:0]        tb_code;
    logic [BYTE_W-1:0] settle_cnt;
    chlist_t           chlist;
    logic              start_req, cnt_rst;
    logic [1:0]        err_clr;
    logic              tb_run, tb_restart, tb_tick;

    adc_seq_regs #(.ID_VALUE(ID_VALUE)) regs_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_addr   (bus_addr),
        .bus_wr     (bus_wr),
        .bus_rd     (bus_rd),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .busy       (seq_busy),
        .result     (seq_result),
        .data_err   (derr),
        .settle_err (serr),
        .enable     (fe_enable),
        .tb_code    (tb_code),
        .settle_cnt (settle_cnt),
        .chlist     (chlist),
        .start_req  (start_req),
        .cnt_rst    (cnt_rst),
        .err_clr    (err_clr)
    );

    adc_seq_timebase #(.STEP_LOG2(TB_STEP_LOG2)) tb_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (tb_run),
        .restart (tb_restart),
        .code    (tb_code),
        .tick    (tb_tick)
    );

    adc_seq_ctrl ctrl_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (fe_enable),
        .start_req  (start_req),
        .cnt_rst    (cnt_rst),
        .err_clr    (err_clr),
        .settle_cnt (settle_cnt),
        .tick       (tb_tick),
        .cnv_done   (cnv_done),
        .cnv_data   (cnv_data),
        .busy       (seq_busy),
        .cnv_start  (cnv_start),
        .tb_run     (tb_run),
        .tb_restart (tb_restart),
        .result     (seq_result),
        .data_err   (derr),
        .settle_err (serr)
    );

    assign fe_chan       = chlist.chan;
    assign fe_gain       = chlist.gain;
    assign fe_mux_en     = chlist.mux_en;
    assign fe_board_only = chlist.board_only;

endmodule

// File: rtl/adc_acq_seq_chk.sv
module adc_acq_seq_chk
    import adc_seq_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              bus_rd,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              enable,
    input logic              busy,
    input logic              cnv_start,
    input logic              cnv_done,
    input logic [RES_W-1:0]  result
);
    AST_FIRE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        cnv_start |=> !cnv_start); // R3

    AST_START_GOES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == OFS_SWSTART && enable) |=> busy); // R2

    AST_RESULT_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(result) |-> (!busy && $past(busy))); // R4

    AST_BUSY_ENDS_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy) && $past(enable)) |-> $past(cnv_done)); // R4

    AST_DISABLE_IDLES: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !busy); // R10

endmodule

bind adc_acq_seq adc_acq_seq_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .enable    (fe_enable),
    .busy      (seq_busy),
    .cnv_start (cnv_start),
    .cnv_done  (cnv_done),
    .result    (seq_result)
);

// File: tb/adc_acq_seq_tb_top.sv
module adc_acq_seq_tb_top;
    localparam int STEP = 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  addr = '0;
    logic        wr = 1'b0;
    logic        rd = 1'b0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic        cnv_start;
    logic        cnv_done = 1'b0;
    logic [15:0] cnv_data = '0;
    logic        fe_enable, fe_mux_en, fe_board_only;
    logic [1:0]  fe_chan, fe_gain;

    int checks = 0;
    int fails  = 0;
    bit done_flag = 0;

    always #5 clk = ~clk;

    adc_acq_seq #(.TB_STEP_LOG2(STEP)) dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .bus_addr      (addr),
        .bus_wr        (wr),
        .bus_rd        (rd),
        .bus_wdata     (wdata),
        .bus_rdata     (rdata),
        .cnv_start     (cnv_start),
        .cnv_done      (cnv_done),
        .cnv_data      (cnv_data),
        .fe_enable     (fe_enable),
        .fe_chan       (fe_chan),
        .fe_gain       (fe_gain),
        .fe_mux_en     (fe_mux_en),
        .fe_board_only (fe_board_only)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // all bus tasks are entered and left at a falling edge
    task automatic wr_reg(input logic [7:0] a, input logic [7:0] d);
        addr = a; wdata = d; wr = 1'b1;
        @(posedge clk);
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic rd_start();
        addr = 8'h04; rd = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rd = 1'b0;
    endtask

    task automatic peek(input logic [7:0] a, output logic [7:0] d);
        addr = a;
        #1 d = rdata;
    endtask

    task automatic wait_fire(output int k);
        k = 0;
        while (!cnv_start && k < 3000) begin
            @(negedge clk);
            k++;
        end
    endtask

    task automatic finish_conv(input logic [15:0] d);
        cnv_data = d; cnv_done = 1'b1;
        @(posedge clk);
        @(negedge clk);
        cnv_done = 1'b0;
    endtask

    task automatic summary();
        if (!done_flag) begin
            done_flag = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        logic [7:0]  b, lo, hi;
        logic [15:0] d;
        int k, k2, seen;

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        peek(8'h00, b); chk("R1 ident", b, 8'h77);
        peek(8'h01, b); chk("R1 cmdstat", b, 8'h00);
        peek(8'h02, b); chk("R1 res lo", b, 8'h00);
        peek(8'h03, b); chk("R1 res hi", b, 8'h00);
        peek(8'h12, b); chk("R1 status", b, 8'h00);
        chk("R1 no start", cnv_start, 1'b0);

        // R11 enable readback
        wr_reg(8'h10, 8'h04);
        peek(8'h10, b); chk("R11 config readback", b, 8'h04);
        chk("R11 fe_enable", fe_enable, 1'b1);

        // R2 R3 R4 R7 sweep of timebase and settle count
        for (int code = 0; code < 4; code++) begin
            for (int n = 0; n < 10; n++) begin
                wr_reg(8'h12, 8'h03);
                wr_reg(8'h11, 8'(code << 1));
                wr_reg(8'h15, 8'(n));
                rd_start();
                peek(8'h12, b);
                chk("R2 R7 status after start", b, (n == 0) ? 8'h81 : 8'h80);
                wait_fire(k);
                chk("R3 fire delay", k, n * (1 << (code * STEP)) + 1);
                @(negedge clk);
                chk("R3 fire width", cnv_start, 1'b0);
                peek(8'h01, b); chk("R2 busy while waiting", b, 8'h80);
                d = 16'(n * 4099 + code * 777 + 16'h8001);
                finish_conv(d);
                peek(8'h02, lo); peek(8'h03, hi);
                chk("R4 result", {hi, lo}, d);
                peek(8'h12, b); chk("R4 pending cleared", b[7], 1'b0);
            end
        end

        // R5 done while idle
        peek(8'h02, lo); peek(8'h03, hi); d = {hi, lo};
        finish_conv(16'h1234);
        peek(8'h02, lo); peek(8'h03, hi);
        chk("R5 idle done ignored", {hi, lo}, d);

        // R6 start while busy
        wr_reg(8'h12, 8'h03);
        wr_reg(8'h11, 8'h06);
        wr_reg(8'h15, 8'd6);
        rd_start();
        repeat (3) @(negedge clk);
        rd_start();
        peek(8'h12, b); chk("R6 data error set", b, 8'h82);
        wait_fire(k2);
        chk("R6 timing kept", 4 + k2, 6 * 8 + 1);
        @(negedge clk);
        finish_conv(16'hBEEF);

        // R8 error clearing, also settle error via R7
        wr_reg(8'h15, 8'd0);
        rd_start();
        wait_fire(k);
        chk("R7 zero count fire", k, 1);
        @(negedge clk);
        finish_conv(16'h0F0F);
        peek(8'h12, b); chk("R8 both errors", b, 8'h03);
        wr_reg(8'h12, 8'h02);
        peek(8'h12, b); chk("R8 clear data error only", b, 8'h01);
        wr_reg(8'h12, 8'h05);
        peek(8'h12, b); chk("R8 clear settle error, bit2 zero", b, 8'h00);

        // R9 counter restart
        wr_reg(8'h11, 8'h04);
        wr_reg(8'h15, 8'd5);
        rd_start();
        repeat (6) @(negedge clk);
        wr_reg(8'h1B, 8'h00);
        wait_fire(k2);
        chk("R9 restart delay", 7 + k2, 7 + 5 * 4 + 1);
        @(negedge clk);
        finish_conv(16'h7FFF);
        peek(8'h02, lo); peek(8'h03, hi);
        chk("R4 result after restart", {hi, lo}, 16'h7FFF);

        // R10 disabled start
        wr_reg(8'h12, 8'h03);
        wr_reg(8'h10, 8'h00);
        chk("R11 fe_enable low", fe_enable, 1'b0);
        rd_start();
        seen = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (cnv_start) seen = 1;
        end
        peek(8'h12, b); chk("R10 disabled start ignored", b, 8'h00);
        chk("R10 no fire when disabled", seen, 0);

        // R10 abort by disable
        wr_reg(8'h10, 8'h04);
        wr_reg(8'h11, 8'h06);
        wr_reg(8'h15, 8'd9);
        rd_start();
        repeat (3) @(negedge clk);
        wr_reg(8'h10, 8'h00);
        @(negedge clk);
        peek(8'h01, b); chk("R10 abort busy low", b, 8'h00);
        seen = 0;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if (cnv_start) seen = 1;
        end
        chk("R10 no fire after abort", seen, 0);
        wr_reg(8'h10, 8'h04);

        // R11 channel list sweep and option readback
        for (int v = 0; v < 64; v++) begin
            wr_reg(8'h80, 8'(v) | 8'hC0);
            peek(8'h80, b);
            chk("R11 chlist", {fe_board_only, fe_gain, fe_mux_en, fe_chan, b},
                {6'(v), 8'(v)});
        end
        wr_reg(8'h11, 8'hFF);
        peek(8'h11, b); chk("R11 option readback", b, 8'h3F);

        summary();
    end

endmodule